// File: doc/BRIEF.md
# Deferred Error Status Register

This block holds a 32-bit status word. The word records that an error synchronization barrier has absorbed a pending asynchronous system error. A capture strobe from the barrier logic carries the error type, the external-abort type and a 6-bit fault status code. The block packs these into one of three bit layouts:

- The hypervisor layout, used when the capture happens at the hypervisor or top privilege level.
- The short-descriptor layout, used at user or kernel level when the translation format is short.
- The long-descriptor layout, used at user or kernel level when the translation format is long.

The block also decodes system-register read and write requests against this word. The outcome of a request depends on the requester's privilege level and on four control inputs: a hypervisor trap enable, an abort-routing control, a top-level external-abort routing control and a halted flag. A request has one of five outcomes:

- It accesses the physical register.
- It is redirected to a separate virtual copy.
- It reads as zero, with writes discarded.
- It traps to the hypervisor with a fixed syndrome code.
- It is flagged as undefined.

Every outcome is reported one cycle after the request.

Top module: `deferred_err_status`

## Requirements
- R1: After reset, the physical register and the virtual copy both read as zero, and rd_valid_o, trap_o and undef_o are low.
- R2: A capture at level 2 (hypervisor) or level 3 (top) stores the error type in [11:10], the external-abort type in [9] and the 6-bit status code in [5:0]. Bits [30:12] and [8:6] are zero.
- R3: A capture at level 0 or 1 with cap_long_fmt_i=0 stores the error type in [15:14], the external-abort type in [12], status bit 4 in [10] and status bits 3:0 in [3:0]. Bit [9] is 0, and all other bits below 31 are zero.
- R4: A capture at level 0 or 1 with cap_long_fmt_i=1 stores the error type in [15:14], the external-abort type in [12], a 1 in [9] and the 6-bit status code in [5:0]. All other bits below 31 are zero.
- R5: Bit 31 of every captured value is 1 when HAS_SYNC_SRC=1 and 0 when HAS_SYNC_SRC=0.
- R6: Any request at level 0 raises undef_o one cycle later. It produces no read data, and neither copy changes.
- R7: At level 1 with hyp_trap_en_i=1, a request raises trap_o one cycle later with trap_code_o=0x03. Neither copy changes. This outcome has priority over R8 and R9.
- R8: At level 1 with no trap and abort_route_i=1, reads return the virtual copy and writes update only the virtual copy.
- R9: At level 1 with no trap and no abort routing, and at level 2, the request reads as zero and its write is discarded whenever ea_route_i=1 and halted_i=0. When halted_i=1, the request goes to the physical register.
- R10: At level 3 every request accesses the physical register directly. Any remaining level-1 or level-2 case also accesses it directly.
- R11: A read issued in the cycle after a capture returns the captured value.
- R12: When a capture and a physical-register write occur in the same cycle, the captured value is stored. A write to the virtual copy in that cycle still takes effect.
- R13: Outputs respond exactly one cycle after a request. rd_valid_o rises only for reads, and at most one of rd_valid_o, trap_o and undef_o is high. With no request, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cap_valid_i | input | 1 | Barrier deferred an error this cycle |
| cap_lvl_i | input | 2 | Privilege level at capture (0 user, 1 kernel, 2 hypervisor, 3 top) |
| cap_long_fmt_i | input | 1 | Translation format at capture: 1 long, 0 short |
| cap_err_type_i | input | 2 | Asynchronous error type |
| cap_ext_i | input | 1 | External-abort type |
| cap_fsc_i | input | 6 | Fault status code |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 write, 0 read |
| req_lvl_i | input | 2 | Privilege level of the requester |
| req_wdata_i | input | 32 | Write data |
| hyp_trap_en_i | input | 1 | Hypervisor trap enable for this register |
| abort_route_i | input | 1 | Abort routing to hypervisor; redirects to the virtual copy |
| ea_route_i | input | 1 | Top-level external-abort routing |
| halted_i | input | 1 | Core is in debug halt |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| trap_o | output | 1 | Request trapped to the hypervisor |
| trap_code_o | output | 6 | Trap syndrome code, nonzero only with trap_o |
| undef_o | output | 1 | Request is undefined |

## Verification
The bench builds the block with HAS_SYNC_SRC=1 and TRAP_CODE=0x03. With these values, every capture input combination can be swept: 4 levels, 2 formats, 4 error types, 2 abort types and 64 status codes. Each capture is read back on the following cycle, and the expected word is rebuilt arithmetically. A second sweep covers all 128 combinations of level, direction, trap enable, abort routing, external-abort routing and halt. For each one, the bench checks the response outputs and then reads back both the physical and the virtual copy. This exposes wrong priorities and any stray or missing write.

// File: rtl/des_pkg.sv
package des_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned FSC_W  = 6;
  localparam int unsigned ET_W   = 2;
  localparam int unsigned CODE_W = 6;

  typedef enum logic [1:0] {
    LVL_USR = 2'd0,
    LVL_KRN = 2'd1,
    LVL_HYP = 2'd2,
    LVL_TOP = 2'd3
  } lvl_e;

  typedef enum logic [2:0] {
    OUT_UNDEF  = 3'd0,
    OUT_TRAP   = 3'd1,
    OUT_VIRT   = 3'd2,
    OUT_RAZ    = 3'd3,
    OUT_DIRECT = 3'd4
  } outc_e;

  typedef struct packed {
    logic [ET_W-1:0]  err_type;
    logic             ext;
    logic [FSC_W-1:0] fsc;
  } synd_t;
endpackage

// File: rtl/des_pack.sv
module des_pack
  import des_pkg::*;
#(
  parameter bit HAS_SYNC_SRC = 1'b1
) (
  input  logic [1:0]       lvl_i,
  input  logic             long_fmt_i,
  input  synd_t            synd_i,
  output logic [REG_W-1:0] word_o
);
  logic       a_bit;
  logic [1:0] layout;

  generate
    if (HAS_SYNC_SRC) begin : g_sync
      assign a_bit = 1'b1;
    end else begin : g_nosync
      assign a_bit = 1'b0;
    end
  endgenerate

  // 0: hypervisor, 1: short descriptor, 2: long descriptor
  always_comb begin
    if (lvl_i == LVL_HYP || lvl_i == LVL_TOP) layout = 2'd0;
    else if (!long_fmt_i)                     layout = 2'd1;
    else                                      layout = 2'd2;
  end

  always_comb begin
    unique case (layout)
      2'd0:    word_o = {a_bit, 19'b0, synd_i.err_type, synd_i.ext, 3'b0, synd_i.fsc};
      2'd1:    word_o = {a_bit, 15'b0, synd_i.err_type, 1'b0, synd_i.ext, 1'b0,
                         synd_i.fsc[4], 1'b0, 5'b0, synd_i.fsc[3:0]};
      default: word_o = {a_bit, 15'b0, synd_i.err_type, 1'b0, synd_i.ext, 2'b0,
                         1'b1, 3'b0, synd_i.fsc};
    endcase
  end
endmodule

// File: rtl/des_access.sv
module des_access
  import des_pkg::*;
#(
  parameter logic [CODE_W-1:0] TRAP_CODE = 6'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_lvl_i,
  input  logic              hyp_trap_en_i,
  input  logic              abort_route_i,
  input  logic              ea_route_i,
  input  logic              halted_i,
  input  logic [REG_W-1:0]  phys_q_i,
  input  logic [REG_W-1:0]  virt_q_i,
  output logic              wr_phys_o,
  output logic              wr_virt_o,
  output logic              rd_valid_o,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              trap_o,
  output logic [CODE_W-1:0] trap_code_o,
  output logic              undef_o
);
  outc_e            outc;
  logic             raz_cond;
  logic             is_rd;
  logic [REG_W-1:0] rd_mux;
  logic             rd_valid_q, trap_q, undef_q;
  logic [REG_W-1:0] rd_data_q;

  assign raz_cond = ea_route_i && !halted_i;

  always_comb begin
    unique case (lvl_e'(req_lvl_i))
      LVL_USR: outc = OUT_UNDEF;
      LVL_KRN: begin
        if (hyp_trap_en_i)      outc = OUT_TRAP;
        else if (abort_route_i) outc = OUT_VIRT;
        else if (raz_cond)      outc = OUT_RAZ;
        else                    outc = OUT_DIRECT;
      end
      LVL_HYP: outc = raz_cond ? OUT_RAZ : OUT_DIRECT;
      default: outc = OUT_DIRECT;
    endcase
  end

  assign wr_phys_o = req_valid_i && req_write_i && (outc == OUT_DIRECT);
  assign wr_virt_o = req_valid_i && req_write_i && (outc == OUT_VIRT);
  assign is_rd = req_valid_i && !req_write_i &&
                 (outc == OUT_DIRECT || outc == OUT_VIRT || outc == OUT_RAZ);

  always_comb begin
    unique case (outc)
      OUT_DIRECT: rd_mux = phys_q_i;
      OUT_VIRT:   rd_mux = virt_q_i;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      trap_q     <= 1'b0;
      undef_q    <= 1'b0;
    end else begin
      rd_valid_q <= is_rd;
      rd_data_q  <= is_rd ? rd_mux : '0;
      trap_q     <= req_valid_i && (outc == OUT_TRAP);
      undef_q    <= req_valid_i && (outc == OUT_UNDEF);
    end
  end

  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign trap_o      = trap_q;
  assign trap_code_o = trap_q ? TRAP_CODE : '0;
  assign undef_o     = undef_q;
endmodule

// File: rtl/des_store.sv
module des_store
  import des_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_en_i,
  input  logic [REG_W-1:0] cap_word_i,
  input  logic             wr_phys_i,
  input  logic             wr_virt_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] phys_q_o,
  output logic [REG_W-1:0] virt_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phys_q_o <= '0;
    else if (cap_en_i)  phys_q_o <= cap_word_i;  // capture beats software write
    else if (wr_phys_i) phys_q_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        virt_q_o <= '0;
    else if (wr_virt_i) virt_q_o <= wdata_i;
  end
endmodule

// File: rtl/deferred_err_status.sv
module deferred_err_status
  import des_pkg::*;
#(
  parameter bit                HAS_SYNC_SRC = 1'b1,
  parameter logic [CODE_W-1:0] TRAP_CODE    = 6'h03
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_valid_i,
  input  logic [1:0]         cap_lvl_i,
  input  logic               cap_long_fmt_i,
  input  logic [ET_W-1:0]    cap_err_type_i,
  input  logic               cap_ext_i,
  input  logic [FSC_W-1:0]   cap_fsc_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [1:0]         req_lvl_i,
  input  logic [REG_W-1:0]   req_wdata_i,
  input  logic               hyp_trap_en_i,
  input  logic               abort_route_i,
  input  logic               ea_route_i,
  input  logic               halted_i,
  output logic               rd_valid_o,
  output logic [REG_W-1:0]   rd_data_o,
  output logic               trap_o,
  output logic [CODE_W-1:0]  trap_code_o,
  output logic               undef_o
);
  synd_t            synd;
  logic [REG_W-1:0] cap_word, phys_q, virt_q;
  logic             wr_phys, wr_virt;

  assign synd = '{err_type: cap_err_type_i, ext: cap_ext_i, fsc: cap_fsc_i};

  des_pack #(.HAS_SYNC_SRC(HAS_SYNC_SRC)) u_pack (
    .lvl_i      (cap_lvl_i),
    .long_fmt_i (cap_long_fmt_i),
    .synd_i     (synd),
    .word_o     (cap_word)
  );

  des_access #(.TRAP_CODE(TRAP_CODE)) u_access (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_write_i   (req_write_i),
    .req_lvl_i     (req_lvl_i),
    .hyp_trap_en_i (hyp_trap_en_i),
    .abort_route_i (abort_route_i),
    .ea_route_i    (ea_route_i),
    .halted_i      (halted_i),
    .phys_q_i      (phys_q),
    .virt_q_i      (virt_q),
    .wr_phys_o     (wr_phys),
    .wr_virt_o     (wr_virt),
    .rd_valid_o    (rd_valid_o),
    .rd_data_o     (rd_data_o),
    .trap_o        (trap_o),
    .trap_code_o   (trap_code_o),
    .undef_o       (undef_o)
  );

  des_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_en_i   (cap_valid_i),
    .cap_word_i (cap_word),
    .wr_phys_i  (wr_phys),
    .wr_virt_i  (wr_virt),
    .wdata_i    (req_wdata_i),
    .phys_q_o   (phys_q),
    .virt_q_o   (virt_q)
  );
endmodule

// File: rtl/deferred_err_status_chk.sv
module deferred_err_status_chk #(
  parameter bit HAS_SYNC_SRC = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cap_valid_i,
  input logic        req_valid_i,
  input logic        req_write_i,
  input logic [1:0]  req_lvl_i,
  input logic        hyp_trap_en_i,
  input logic        ea_route_i,
  input logic        halted_i,
  input logic        rd_valid_o,
  input logic [31:0] rd_data_o,
  input logic        trap_o,
  input logic [5:0]  trap_code_o,
  input logic        undef_o
);
  a_r6_user_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_lvl_i == 2'd0 |=> undef_o && !rd_valid_o && !trap_o);

  a_r7_kernel_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_lvl_i == 2'd1 && hyp_trap_en_i |=> trap_o && trap_code_o == 6'h03);

  a_r9_hyp_raz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && req_lvl_i == 2'd2 && ea_route_i && !halted_i
    |=> rd_valid_o && rd_data_o == 32'h0);

  a_r11_capture_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cap_valid_i) && !cap_valid_i && req_valid_i && !req_write_i && req_lvl_i == 2'd3
    |=> rd_valid_o && rd_data_o[31] == HAS_SYNC_SRC);

  a_r13_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_valid_o, trap_o, undef_o}));

  a_r13_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rd_valid_o && !trap_o && !undef_o);

  a_r13_write_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_write_i |=> !rd_valid_o);
endmodule

bind deferred_err_status deferred_err_status_chk #(.HAS_SYNC_SRC(HAS_SYNC_SRC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cap_valid_i   (cap_valid_i),
  .req_valid_i   (req_valid_i),
  .req_write_i   (req_write_i),
  .req_lvl_i     (req_lvl_i),
  .hyp_trap_en_i (hyp_trap_en_i),
  .ea_route_i    (ea_route_i),
  .halted_i      (halted_i),
  .rd_valid_o    (rd_valid_o),
  .rd_data_o     (rd_data_o),
  .trap_o        (trap_o),
  .trap_code_o   (trap_code_o),
  .undef_o       (undef_o)
);

// File: tb/sim_deferred_err_status.sv
`timescale 1ns/1ps
module sim_deferred_err_status;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cap_valid_i = 0, cap_long_fmt_i = 0, cap_ext_i = 0;
  logic [1:0]  cap_lvl_i = 0, cap_err_type_i = 0;
  logic [5:0]  cap_fsc_i = 0;
  logic        req_valid_i = 0, req_write_i = 0;
  logic [1:0]  req_lvl_i = 0;
  logic [31:0] req_wdata_i = 0;
  logic        hyp_trap_en_i = 0, abort_route_i = 0, ea_route_i = 0, halted_i = 0;
  logic        rd_valid_o, trap_o, undef_o;
  logic [31:0] rd_data_o;
  logic [5:0]  trap_code_o;

  int n_chk = 0, n_fail = 0;
  logic        s_rv, s_tr, s_ud;
  logic [31:0] s_rd;
  logic [5:0]  s_tc;

  always #10 clk_i = ~clk_i;

  deferred_err_status #(.HAS_SYNC_SRC(1'b1), .TRAP_CODE(6'h03)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at negedge: drive request, sample one cycle later
  task automatic access(input logic [1:0] lvl, input logic wr, input logic [31:0] wd,
                        input logic te, input logic ar, input logic ea, input logic ht);
    req_valid_i = 1; req_write_i = wr; req_lvl_i = lvl; req_wdata_i = wd;
    hyp_trap_en_i = te; abort_route_i = ar; ea_route_i = ea; halted_i = ht;
    @(negedge clk_i);
    s_rv = rd_valid_o; s_rd = rd_data_o; s_tr = trap_o; s_tc = trap_code_o; s_ud = undef_o;
    req_valid_i = 0; req_write_i = 0;
    hyp_trap_en_i = 0; abort_route_i = 0; ea_route_i = 0; halted_i = 0;
  endtask

  task automatic rd_phys(output logic [31:0] v);
    access(2'd3, 0, 0, 0, 0, 0, 0); v = s_rd;
  endtask
  task automatic rd_virt(output logic [31:0] v);
    access(2'd1, 0, 0, 0, 1, 0, 0); v = s_rd;
  endtask

  function automatic logic [31:0] exp_word(int lvl, int lf, int et, int ex, int fs);
    int unsigned w = 32'h8000_0000;  // R5 bit 31
    if (lvl >= 2) w = w + et * 1024 + ex * 512 + fs;
    else if (lf == 0) w = w + et * 16384 + ex * 4096 + ((fs / 16) % 2) * 1024 + (fs % 16);
    else w = w + et * 16384 + ex * 4096 + 512 + fs;
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 rd_valid", {31'b0, rd_valid_o}, 0);
    chk("R1 trap", {31'b0, trap_o}, 0);
    chk("R1 undef", {31'b0, undef_o}, 0);
    rd_phys(v); chk("R1 phys", v, 0);
    rd_virt(v); chk("R1 virt", v, 0);
    @(negedge clk_i);
    chk("R13 idle", {29'b0, rd_valid_o, trap_o, undef_o}, 0);

    // capture sweep, read back on next cycle (R11)
    for (int lvl = 0; lvl < 4; lvl++)
      for (int lf = 0; lf < 2; lf++)
        for (int et = 0; et < 4; et++)
          for (int ex = 0; ex < 2; ex++)
            for (int fs = 0; fs < 64; fs++) begin
              string tag;
              cap_valid_i = 1; cap_lvl_i = lvl[1:0]; cap_long_fmt_i = lf[0];
              cap_err_type_i = et[1:0]; cap_ext_i = ex[0]; cap_fsc_i = fs[5:0];
              @(negedge clk_i);
              cap_valid_i = 0;
              rd_phys(v);
              tag = (lvl >= 2) ? "R2/R11" : (lf == 0) ? "R3/R11" : "R4/R11";
              chk(tag, v, exp_word(lvl, lf, et, ex, fs));
              if (fs == 0 && et == 0) chk("R5 bit31", {31'b0, v[31]}, 1);
            end

    // access outcome sweep
    for (int i = 0; i < 128; i++) begin
      logic [1:0]  lvl;
      logic        wr, te, ar, ea, ht;
      logic [31:0] p, vv, w, ep, ev, erd;
      logic        erv, etr, eud;
      string       tag;
      lvl = i[1:0]; wr = i[2]; te = i[3]; ar = i[4]; ea = i[5]; ht = i[6];
      p = 32'hA5A5_0000 ^ i; vv = 32'h5A5A_0000 ^ i; w = 32'h1234_5600 ^ i;
      access(2'd3, 1, p, 0, 0, 0, 0);
      access(2'd1, 1, vv, 0, 1, 0, 0);
      ep = p; ev = vv; erd = 0; erv = 0; etr = 0; eud = 0;
      if (lvl == 0) begin eud = 1; tag = "R6"; end
      else if (lvl == 1 && te) begin etr = 1; tag = "R7"; end
      else if (lvl == 1 && ar) begin
        tag = "R8"; if (wr) ev = w; else begin erv = 1; erd = vv; end
      end else if (lvl != 3 && ea && !ht) begin
        tag = "R9"; if (!wr) erv = 1;
      end else begin
        tag = "R10"; if (wr) ep = w; else begin erv = 1; erd = p; end
      end
      access(lvl, wr, w, te, ar, ea, ht);
      chk({tag, " undef"}, {31'b0, s_ud}, {31'b0, eud});
      chk({tag, " trap"}, {31'b0, s_tr}, {31'b0, etr});
      chk({tag, " trap_code"}, {26'b0, s_tc}, etr ? 32'h3 : 32'h0);
      chk({tag, " R13 rd_valid"}, {31'b0, s_rv}, {31'b0, erv});
      chk({tag, " rd_data"}, s_rd, erd);
      rd_phys(v); chk({tag, " phys after"}, v, ep);
      rd_virt(v); chk({tag, " virt after"}, v, ev);
    end

    // R12: capture and direct write in the same cycle
    cap_valid_i = 1; cap_lvl_i = 2; cap_long_fmt_i = 0;
    cap_err_type_i = 2; cap_ext_i = 1; cap_fsc_i = 6'h15;
    access(2'd3, 1, 32'hDEAD_BEEF, 0, 0, 0, 0);
    cap_valid_i = 0;
    rd_phys(v); chk("R12 capture wins", v, exp_word(2, 0, 2, 1, 21));
    // R12: capture alongside a virtual write
    cap_valid_i = 1; cap_lvl_i = 1; cap_long_fmt_i = 1;
    cap_err_type_i = 1; cap_ext_i = 0; cap_fsc_i = 6'h2A;
    access(2'd1, 1, 32'hCAFE_0001, 0, 1, 0, 0);
    cap_valid_i = 0;
    rd_phys(v); chk("R12 phys capture", v, exp_word(1, 1, 1, 0, 42));
    rd_virt(v); chk("R12 virt written", v, 32'hCAFE_0001);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule